// File: doc/BRIEF.md
# E1 Line Loss-of-Signal Detector

This block decides, for one E1 receive channel, whether the line has gone silent. It sees the recovered bipolar data as two unipolar rails (positive and negative marks), one bit per recovered clock. That clock arrives as a one-cycle enable on the system clock. A digital zero-run check is combined with a low-level flag from the analog front end. The combined loss indication drives a status pin. It also gates the receive data rails to a fixed low level, unless gating is disabled.

The digital check uses different rules to set and to clear. It declares loss after a long unbroken run of zero bits. It clears only after the ones density has stayed acceptable for a full window and no long zero run is in progress. Reset, power-down and loss of the reference clock each force the indication high. The last two also put the digital detector back into its lost state, so the link has to qualify again once they end.

Top module: `los_detector`

## Requirements
- R1: The digital detector enters the lost state on the clock after the 175th consecutive zero bit is taken in (a bit is a mark when either rail is 1). After 174 zeros it has not yet done so.
- R2: Any mark bit on either rail restarts the zero-run count, so two runs of 170 zeros separated by one mark raise no loss.
- R3: The lost state clears only after every 32-bit window of received bits, sliding one bit at a time, has held at least 4 marks for 32 bits in a row. A pattern of one mark in every 8 bits clears it. One mark in every 9 bits never does.
- R4: Clearing also requires that the current zero run is shorter than 100 bits.
- R5: `los_o` is the OR of the digital state and `analog_low`, and it follows `analog_low` combinationally. The analog flag leaves the digital state untouched.
- R6: While `rst_n` is low, `los_o` is high. After reset the digital detector starts in the lost state.
- R7: While `pwr_down` is high, `los_o` is high and the digital state is forced to lost. After release it stays lost until R3 is met again.
- R8: `ref_lost` raises `los_o` in the same cycle and forces the digital state to lost.
- R9: While `los_o` is high and `gate_dis` is low, `rx_pos_o` and `rx_neg_o` are 0. Otherwise they equal `rx_pos_i` and `rx_neg_i`.
- R10: Clock cycles with `bit_en` low change no count and no window, whatever the rails carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Recovered-clock enable, one cycle per received bit |
| rx_pos_i | input | 1 | Recovered positive-mark rail |
| rx_neg_i | input | 1 | Recovered negative-mark rail |
| analog_low | input | 1 | Analog input-level-below-threshold flag (synchronous) |
| pwr_down | input | 1 | Channel power-down |
| ref_lost | input | 1 | Reference clock loss flag |
| gate_dis | input | 1 | 1 keeps the receive rails passing during loss |
| los_o | output | 1 | Loss-of-signal indication |
| rx_pos_o | output | 1 | Gated positive rail |
| rx_neg_o | output | 1 | Gated negative rail |

## Verification
A zero-run counter that is wrong shows at `los_o` when the 175th zero arrives: the indication rises one bit early or late, or a mark fails to restart the run. A fault in the density window or in its streak counter shows as a clear on the wrong bit after recovery. The sparse 1-in-8 and 1-in-9 patterns separate an off-by-one in the threshold within about 40 bits. A forced state that is not stored shows as `los_o` dropping in the first cycle after power-down or reference loss ends. A gating fault shows on the receive rails in the same cycle as the loss.

// File: rtl/los_pkg.sv
// Shared types for the loss-of-signal detector.
package los_pkg;
    // Digital link state held by the detector.
    typedef enum logic {
        LINK_UP   = 1'b0,
        LINK_LOST = 1'b1
    } link_state_e;
endpackage

// File: rtl/los_zero_run.sv
// Counts consecutive zero bits in the recovered stream.
// Assumes: bit_en marks one recovered bit per pulse; mark is valid with it.
// The count saturates at SET_ZEROS and restarts on any mark.
module los_zero_run #(
    parameter int SET_ZEROS = 175,
    parameter int CLR_ZEROS = 100
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_en,
    input  logic                              mark,
    output logic [$clog2(SET_ZEROS+1)-1:0]    zrun_q,
    output logic                              run_long,
    output logic                              run_short
);
    localparam int ZW = $clog2(SET_ZEROS + 1);
    localparam logic [ZW-1:0] SET_C = ZW'(SET_ZEROS);
    localparam logic [ZW-1:0] CLR_C = ZW'(CLR_ZEROS);

    // Zero-run counter: clear on a mark, count up to saturation on a zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (bit_en) begin
            if (mark) begin
                zrun_q <= '0;
            end else if (zrun_q != SET_C) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    // Threshold flags for the state logic.
    always_comb begin
        run_long  = (zrun_q == SET_C);
        run_short = (zrun_q < CLR_C);
    end
endmodule

// File: rtl/los_density.sv
// Sliding-window ones-density qualifier.
// Assumes: one bit per bit_en pulse. Keeps the last WIN bits, counts their
// marks, and reports dens_ok once the window has held MIN_ONES or more
// marks for WIN consecutive bits.
module los_density #(
    parameter int WIN      = 32,
    parameter int MIN_ONES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mark,
    output logic dens_ok
);
    localparam int CW = $clog2(WIN + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_ONES);
    localparam logic [CW-1:0] WIN_C = CW'(WIN);

    logic [WIN-1:0] win_q;
    logic [CW-1:0]  ones_q;
    logic [CW-1:0]  ones_nxt;
    logic [CW-1:0]  streak_q;
    logic           pass_nxt;

    // Next window mark count: add the new bit, drop the oldest.
    always_comb begin
        ones_nxt = ones_q + CW'(mark) - CW'(win_q[WIN-1]);
        pass_nxt = (ones_nxt >= MIN_C);
    end

    // Window shift, mark count and passing-streak counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            ones_q   <= '0;
            streak_q <= '0;
        end else if (bit_en) begin
            win_q  <= {win_q[WIN-2:0], mark};
            ones_q <= ones_nxt;
            if (!pass_nxt) begin
                streak_q <= '0;
            end else if (streak_q != WIN_C) begin
                streak_q <= streak_q + 1'b1;
            end
        end
    end

    // Qualified once a full window of passing checks has been seen.
    assign dens_ok = (streak_q == WIN_C);
endmodule

// File: rtl/los_state.sv
// Digital loss state with asymmetric set and clear.
// Assumes: inputs are registered statistics; force_loss is synchronous.
// Sets on a long zero run, clears on the density and short-run qualifiers.
module los_state
    import los_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_loss,
    input  logic run_long,
    input  logic run_short,
    input  logic dens_ok,
    output logic dig_lost
);
    link_state_e st_q;

    // State update: forcing first, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LINK_LOST;
        end else if (force_loss) begin
            st_q <= LINK_LOST;
        end else begin
            case (st_q)
                LINK_UP:   if (run_long) st_q <= LINK_LOST;
                LINK_LOST: if (dens_ok && run_short) st_q <= LINK_UP;
                default:   st_q <= LINK_LOST;
            endcase
        end
    end

    assign dig_lost = (st_q == LINK_LOST);
endmodule

// File: rtl/los_detector.sv
// Per-channel E1 loss-of-signal detector top.
// Assumes: a single system clock; the recovered clock arrives as bit_en;
// analog_low, pwr_down and ref_lost are synchronous to clk.
// Combines the digital state with the analog flag and forcing inputs,
// and gates the receive rails during loss unless gate_dis is set.
module los_detector #(
    parameter int SET_ZEROS = 175,
    parameter int CLR_ZEROS = 100,
    parameter int WIN       = 32,
    parameter int MIN_ONES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    input  logic analog_low,
    input  logic pwr_down,
    input  logic ref_lost,
    input  logic gate_dis,
    output logic los_o,
    output logic rx_pos_o,
    output logic rx_neg_o
);
    localparam int ZW = $clog2(SET_ZEROS + 1);
    localparam int NRAIL = 2;

    logic          mark;
    logic [ZW-1:0] zrun_q;
    logic          run_long;
    logic          run_short;
    logic          dens_ok;
    logic          dig_lost;
    logic          force_loss;
    logic          gate_on;
    logic [NRAIL-1:0] rail_in;
    logic [NRAIL-1:0] rail_out;

    assign mark       = rx_pos_i | rx_neg_i;
    assign force_loss = pwr_down | ref_lost;

    los_zero_run #(.SET_ZEROS(SET_ZEROS), .CLR_ZEROS(CLR_ZEROS)) u_zrun (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark),
        .zrun_q(zrun_q), .run_long(run_long), .run_short(run_short)
    );

    los_density #(.WIN(WIN), .MIN_ONES(MIN_ONES)) u_dens (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark),
        .dens_ok(dens_ok)
    );

    los_state u_state (
        .clk(clk), .rst_n(rst_n), .force_loss(force_loss),
        .run_long(run_long), .run_short(run_short), .dens_ok(dens_ok),
        .dig_lost(dig_lost)
    );

    // Final indication: reset, forcing, analog flag or digital state.
    always_comb begin
        los_o   = !rst_n || dig_lost || analog_low || force_loss;
        gate_on = los_o && !gate_dis;
    end

    assign rail_in = {rx_neg_i, rx_pos_i};

    // Per-rail gating to a fixed low level during loss.
    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        assign rail_out[g] = rail_in[g] & ~gate_on;
    end

    assign rx_pos_o = rail_out[0];
    assign rx_neg_o = rail_out[1];
endmodule

// File: rtl/los_detector_chk.sv
// Property checker for los_detector, attached by bind.
module los_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic mark,
    input logic analog_low,
    input logic pwr_down,
    input logic ref_lost,
    input logic gate_dis,
    input logic los_o,
    input logic rx_pos_o,
    input logic rx_neg_o,
    input logic run_long,
    input logic dens_ok,
    input logic dig_lost
);
    a_r1_set_on_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_long |=> dig_lost);
    a_r2_mark_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && mark) |=> !run_long);
    a_r3_clear_needs_density: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_lost) |-> $past(dens_ok));
    a_r5_analog_raises: assert property (@(posedge clk) disable iff (!rst_n)
        analog_low |-> los_o);
    a_r6_reset_raises: assert property (@(posedge clk)
        !rst_n |-> los_o);
    a_r7_pd_raises: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> los_o);
    a_r7_pd_state: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> dig_lost);
    a_r8_ref_state: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost |=> dig_lost);
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (los_o && !gate_dis) |-> (!rx_pos_o && !rx_neg_o));
    a_r10_idle_run: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(run_long));
    a_r10_idle_dens: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dens_ok));
endmodule

bind los_detector los_detector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark),
    .analog_low(analog_low), .pwr_down(pwr_down), .ref_lost(ref_lost),
    .gate_dis(gate_dis), .los_o(los_o), .rx_pos_o(rx_pos_o),
    .rx_neg_o(rx_neg_o), .run_long(run_long), .dens_ok(dens_ok),
    .dig_lost(dig_lost)
);

// File: tb/los_detector_test.sv
module los_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rx_pos_i = 1'b0;
    logic rx_neg_i = 1'b0;
    logic analog_low = 1'b0;
    logic pwr_down = 1'b0;
    logic ref_lost = 1'b0;
    logic gate_dis = 1'b0;
    logic los_o, rx_pos_o, rx_neg_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference model state
    bit [31:0] m_hist;
    int        m_zrun;
    int        m_streak;
    bit        m_dig;

    typedef struct {
        bit    los;
        bit    pos;
        bit    neg;
        string req;
    } exp_t;
    exp_t sb[$];
    event got;

    always #(CLK_PERIOD/2) clk = ~clk;

    los_detector uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .rx_pos_i(rx_pos_i), .rx_neg_i(rx_neg_i),
        .analog_low(analog_low), .pwr_down(pwr_down), .ref_lost(ref_lost),
        .gate_dis(gate_dis), .los_o(los_o),
        .rx_pos_o(rx_pos_o), .rx_neg_o(rx_neg_o)
    );

    task automatic check(input bit act, input bit exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_hist = '0; m_zrun = 0; m_streak = 0; m_dig = 1'b1;
    endfunction

    // One clock of the state rule against the current statistics.
    function automatic void model_fsm();
        if (pwr_down || ref_lost) m_dig = 1'b1;
        else if (!m_dig && m_zrun == 175) m_dig = 1'b1;
        else if (m_dig && m_streak == 32 && m_zrun < 100) m_dig = 1'b0;
    endfunction

    function automatic void model_bit(input bit mk);
        m_zrun = mk ? 0 : ((m_zrun < 175) ? m_zrun + 1 : 175);
        m_hist = {m_hist[30:0], mk};
        if ($countones(m_hist) >= 4) m_streak = (m_streak < 32) ? m_streak + 1 : 32;
        else m_streak = 0;
    endfunction

    function automatic bit exp_los();
        return m_dig | analog_low | pwr_down | ref_lost;
    endfunction

    // Driver: present one bit, push the expected outputs.
    task automatic send_bit(input bit p, input bit n, input string req);
        exp_t e;
        rx_pos_i = p; rx_neg_i = n; bit_en = 1'b1;
        @(negedge clk);
        model_fsm();
        model_bit(p | n);
        bit_en = 1'b0;
        @(negedge clk);
        model_fsm();
        e.los = exp_los();
        e.pos = p & ~(e.los & ~gate_dis);
        e.neg = n & ~(e.los & ~gate_dis);
        e.req = req;
        sb.push_back(e);
        ->got;
        #1;
    endtask

    task automatic send_run(input int cnt, input bit p, input bit n, input string req);
        for (int i = 0; i < cnt; i++) send_bit(p, n, req);
    endtask

    // Sparse pattern: one mark then (period-1) zeros.
    task automatic send_sparse(input int period, input int cnt, input string req);
        for (int i = 0; i < cnt; i++) send_bit((i % period) == 0, 1'b0, req);
    endtask

    // Change a control input and let one clock pass.
    task automatic set_ctrl(input bit an, input bit pd, input bit rl, input bit dis);
        analog_low = an; pwr_down = pd; ref_lost = rl; gate_dis = dis;
        @(negedge clk);
        model_fsm();
    endtask

    // Monitor: compare the design against the scoreboard.
    initial begin
        forever begin
            @(got);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(los_o, e.los, e.req, "los_o");
                check(rx_pos_o, e.pos, e.req, "rx_pos_o");
                check(rx_neg_o, e.neg, e.req, "rx_neg_o");
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        rx_pos_i = 1'b1;
        repeat (3) @(negedge clk);
        // R6: indication high and rails gated during reset
        check(los_o, 1'b1, "R6", "los in reset");
        check(rx_pos_o, 1'b0, "R9", "rail gated in reset");
        rst_n = 1'b1;
        rx_pos_i = 1'b0;
        @(negedge clk);
        model_fsm();
        check(los_o, 1'b1, "R6", "lost after reset");

        // R3: all-marks recovery clears on bit 35
        send_run(40, 1'b1, 1'b0, "R3");
        check(los_o, 1'b0, "R3", "cleared by marks");

        // R1: 174 zeros keep link, 175th raises
        send_run(174, 1'b0, 1'b0, "R1");
        check(los_o, 1'b0, "R1", "174 zeros");
        send_bit(1'b0, 1'b0, "R1");
        check(los_o, 1'b1, "R1", "175 zeros");
        send_run(20, 1'b0, 1'b0, "R1");

        // R2: a negative-rail mark restarts the run
        send_run(40, 1'b0, 1'b1, "R3");
        send_run(170, 1'b0, 1'b0, "R2");
        send_bit(1'b0, 1'b1, "R2");
        send_run(170, 1'b0, 1'b0, "R2");
        check(los_o, 1'b0, "R2", "split runs");

        // R3: 1-in-9 never clears, 1-in-8 does
        send_run(10, 1'b0, 1'b0, "R1");
        check(los_o, 1'b1, "R1", "lost before sparse");
        send_sparse(9, 100, "R3");
        check(los_o, 1'b1, "R3", "1-in-9 holds loss");
        send_sparse(8, 80, "R3");
        check(los_o, 1'b0, "R3", "1-in-8 clears");

        // R4: clear also waits for a short zero run
        send_run(180, 1'b0, 1'b0, "R4");
        send_run(40, 1'b1, 1'b0, "R4");
        check(los_o, 1'b0, "R4", "cleared with zero run 0");

        // R10: idle cycles do not count zeros
        rx_pos_i = 1'b0; rx_neg_i = 1'b0;
        repeat (300) begin
            @(negedge clk);
            model_fsm();
        end
        check(los_o, 1'b0, "R10", "idle zeros ignored");

        // R5: analog flag ORed, digital state kept
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        check(los_o, 1'b1, "R5", "analog raises");
        send_run(10, 1'b1, 1'b0, "R5");
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        check(los_o, 1'b0, "R5", "analog drop");

        // R9: gating disabled passes rails during loss
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        send_run(4, 1'b1, 1'b0, "R9");
        send_run(4, 1'b0, 1'b1, "R9");
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R7: power-down forces lost state that persists after release
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        check(los_o, 1'b1, "R7", "pd raises");
        send_run(30, 1'b0, 1'b0, "R7");
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        check(los_o, 1'b1, "R7", "lost after pd");
        send_run(40, 1'b1, 1'b0, "R7");
        check(los_o, 1'b0, "R7", "requalified");

        // R8: reference loss raises in the same cycle
        ref_lost = 1'b1;
        #1;
        check(los_o, 1'b1, "R8", "ref loss same cycle");
        @(negedge clk);
        model_fsm();
        send_run(3, 1'b1, 1'b0, "R8");
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        send_run(5, 1'b1, 1'b0, "R8");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule